// File: doc/BRIEF.md
# Infrared Interval Capture Unit

The block times the alternating active (mark) and idle (space) stretches of an infrared receiver line, in system clock cycles. The line is first brought into the clock domain by a two-flop synchronizer. Each level change closes the interval that was running and starts a new count. A completed interval becomes one queued record. The record holds a polarity bit, a duration class and the saturating cycle count.

Five duration classes are recognised. Two of them apply to marks: a long one of about 4 ms and a short one of about half a millisecond. Three apply to spaces: about 4 ms, about 1 ms and about 2 ms. Every class bound is exclusive. The bounds are given in hundredths of a millisecond and are converted to cycles through the `CLK_KHZ` parameter, which defaults to a 50 MHz clock.

A host drains the queue. While `not_empty` is high, it takes `rd_data` and pulses `rd_pop` once for each record.

Top module: `ir_pulse_capture`

## Requirements
- R1: While reset is active and after it is released, `not_empty` and `overflow` are both 0.
- R2: The count field equals the number of clock cycles the synchronized line stayed at the level that just ended. Records are queued in the order their intervals completed.
- R3: Bit CNT_W+3 of `rd_data` is 1 for a mark and 0 for a space. A mark is the line at its active level, which is low when `ACTIVE_LOW` = 1.
- R4: Bits CNT_W+2..CNT_W of `rd_data` carry the class code. The bounds are in hundredths of a millisecond and both ends are excluded. Code 0 is a mark between 401 and 407. Code 1 is a mark between 50 and 56. Code 2 is a space between 390 and 400. Code 3 is a space between 90 and 100. Code 4 is a space between 194 and 200.
- R5: An interval that falls in no class gets code 7. This includes a duration that equals a bound, and a duration that is inside a class belonging to the other polarity.
- R6: The count field saturates at 2^CNT_W−1 and holds there for longer intervals.
- R7: The partial interval that runs from reset up to the first level change is never queued.
- R8: When an interval completes while the queue is full, its record is dropped and `overflow` goes to 1. It stays at 1 until reset, and the records already queued are unchanged.
- R9: A `rd_pop` pulse while the queue is empty has no effect on later records. Each pop while records are present removes exactly one record.
- R10: The queue holds exactly FIFO_DEPTH records before it starts dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ir_in | input | 1 | Raw receiver line, asynchronous |
| rd_pop | input | 1 | Removes the head record when high for one cycle |
| not_empty | output | 1 | At least one record is queued |
| rd_data | output | CNT_W+4 | Head record: {polarity, class[2:0], count[CNT_W-1:0]} |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
The bench builds the block with CLK_KHZ = 100, so every class bound equals its hundredths value in cycles (for example, 401 to 407). This puts each exclusive bound, and a value on either side of it, within a few hundred cycles. CNT_W = 10 saturates the count at 1023, so a single 1100-cycle space reaches the ceiling. FIFO_DEPTH = 4 lets five back-to-back short intervals fill the queue and then drop a record.

// File: rtl/irc_pkg.sv
package irc_pkg;

   typedef enum logic [2:0] {
      CLS_MARK_LONG  = 3'd0,
      CLS_MARK_SHORT = 3'd1,
      CLS_SPACE_LONG = 3'd2,
      CLS_SPACE_1MS  = 3'd3,
      CLS_SPACE_2MS  = 3'd4,
      CLS_NONE       = 3'd7
   } cls_code_e;

   localparam int NUM_CLASSES = 5;

   // bounds in hundredths of a millisecond, both exclusive
   function automatic longint cls_lo_hund(input int idx);
      case (idx)
         0:       return 401;
         1:       return 50;
         2:       return 390;
         3:       return 90;
         default: return 194;
      endcase
   endfunction

   function automatic longint cls_hi_hund(input int idx);
      case (idx)
         0:       return 407;
         1:       return 56;
         2:       return 400;
         3:       return 100;
         default: return 200;
      endcase
   endfunction

   function automatic bit cls_is_mark(input int idx);
      return (idx < 2);
   endfunction

   function automatic longint hund_to_cycles(input longint hund, input longint clk_khz);
      return (hund * clk_khz) / 100;
   endfunction

endpackage

// File: rtl/ir_line_timer.sv
module ir_line_timer #(
   parameter int CNT_W      = 18,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_in,
   output logic             edge_o,
   output logic             mark_o,
   output logic [CNT_W-1:0] dur_o,
   output logic             armed_o
);

   localparam logic             IDLE_LVL = ACTIVE_LOW;
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic             sync1_q, sync2_q, lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             chg;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ir_line_timer: CNT_W must be at least 2");
      end
   endgenerate

   assign chg = sync2_q ^ lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= IDLE_LVL;
         sync2_q <= IDLE_LVL;
         lvl_q   <= IDLE_LVL;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         sync1_q <= ir_in;
         sync2_q <= sync1_q;
         lvl_q   <= sync2_q;
         if (chg) begin
            cnt_q   <= CNT_W'(1);
            armed_q <= 1'b1;
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // the interval just closed had level lvl_q
   generate
      if (ACTIVE_LOW) begin : g_act_low
         assign mark_o = ~lvl_q;
      end else begin : g_act_high
         assign mark_o = lvl_q;
      end
   endgenerate

   assign edge_o  = chg;
   assign dur_o   = cnt_q;
   assign armed_o = armed_q;

   // R2: a level change restarts the count at one
   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (cnt_q == CNT_W'(1)));

   // R2: without a change the count grows by one per cycle
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R6: the ceiling is held
   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ir_interval_classify.sv
module ir_interval_classify
   import irc_pkg::*;
#(
   parameter int CNT_W   = 18,
   parameter int CLK_KHZ = 50000
) (
   input  logic             mark_i,
   input  logic [CNT_W-1:0] dur_i,
   output cls_code_e        code_o
);

   localparam longint CNT_CEIL = (64'd1 << CNT_W) - 1;

   logic [NUM_CLASSES-1:0] hit;

   generate
      for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
         localparam longint LO_CYC = hund_to_cycles(cls_lo_hund(g), CLK_KHZ);
         localparam longint HI_CYC = hund_to_cycles(cls_hi_hund(g), CLK_KHZ);
         localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_CYC);
         localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_CYC);
         localparam logic             POL  = cls_is_mark(g);

         if (HI_CYC > CNT_CEIL) begin : g_too_narrow
            $error("ir_interval_classify: CNT_W too small for class bounds");
         end

         assign hit[g] = (mark_i == POL) && (dur_i > LO_C) && (dur_i < HI_C);
      end
   endgenerate

   always_comb begin
      code_o = CLS_NONE;
      for (int k = NUM_CLASSES - 1; k >= 0; k--) begin
         if (hit[k]) code_o = cls_code_e'(k[2:0]);
      end
   end

endmodule

// File: rtl/ir_entry_fifo.sv
module ir_entry_fifo #(
   parameter int W     = 22,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         not_empty,
   output logic         full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = PTR_W + 1;
   localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
   localparam logic [LVL_W-1:0] LVL_F = LVL_W'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ir_entry_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] level;
   logic             do_push, do_pop;

   assign full      = (level == LVL_F);
   assign not_empty = (level != '0);
   assign do_push   = push && !full;
   assign do_pop    = pop && not_empty;
   assign rdata     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R9: popping an empty queue leaves it empty with the read side still
   a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && pop && !push) |=> (level == '0 && rd_ptr == $past(rd_ptr)));

   // R10: occupancy never passes the depth
   a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_F);

   // R8: a push into a full queue is lost
   a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && wr_ptr == $past(wr_ptr)));

endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
   import irc_pkg::*;
#(
   parameter int CLK_KHZ    = 50000,
   parameter int CNT_W      = 18,
   parameter int FIFO_DEPTH = 16,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_in,
   input  logic             rd_pop,
   output logic             not_empty,
   output logic [CNT_W+3:0] rd_data,
   output logic             overflow
);

   localparam int REC_W = CNT_W + 4;

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("ir_pulse_capture: CLK_KHZ must be positive");
      end
   endgenerate

   logic             chg, is_mark, armed, push, q_full;
   logic [CNT_W-1:0] dur;
   cls_code_e        code;
   logic [REC_W-1:0] rec;
   logic             ovf_q;

   ir_line_timer #(
      .CNT_W      (CNT_W),
      .ACTIVE_LOW (ACTIVE_LOW)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ir_in   (ir_in),
      .edge_o  (chg),
      .mark_o  (is_mark),
      .dur_o   (dur),
      .armed_o (armed)
   );

   ir_interval_classify #(
      .CNT_W   (CNT_W),
      .CLK_KHZ (CLK_KHZ)
   ) u_class (
      .mark_i (is_mark),
      .dur_i  (dur),
      .code_o (code)
   );

   assign push = chg && armed;
   assign rec  = {is_mark, code, dur};

   ir_entry_fifo #(
      .W     (REC_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .wdata     (rec),
      .pop       (rd_pop),
      .rdata     (rd_data),
      .not_empty (not_empty),
      .full      (q_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf_q <= 1'b0;
      else if (push && q_full) ovf_q <= 1'b1;
   end

   assign overflow = ovf_q;

   // R7: nothing is queued before the first level change
   a_r7_unarmed_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !not_empty);

   // R8: the drop flag is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R8: a completion into a full queue raises the flag
   a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (push && q_full) |=> overflow);

endmodule

// File: tb/sim_ir_pulse_capture.sv
module sim_ir_pulse_capture;

   localparam int CW   = 10;
   localparam int DEP  = 4;
   localparam int KHZ  = 100;
   localparam int W    = CW + 4;
   localparam int CEIL = (1 << CW) - 1;
   localparam int NV   = 17;

   // interval lengths; even index = mark (line low), odd = space
   localparam int HOLD [NV] = '{404, 395, 53, 95, 50, 197, 56, 100, 51, 90,
                                395, 404, 407, 199, 402, 1100, 20};
   localparam int CLS  [NV] = '{0, 2, 1, 3, 7, 4, 7, 7, 1, 7,
                                7, 7, 7, 4, 0, 7, 7};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ir_in = 1'b1;
   logic         rd_pop = 1'b0;
   logic         not_empty, overflow;
   logic [W-1:0] rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ir_pulse_capture #(
      .CLK_KHZ    (KHZ),
      .CNT_W      (CW),
      .FIFO_DEPTH (DEP),
      .ACTIVE_LOW (1'b1)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ir_in     (ir_in),
      .rd_pop    (rd_pop),
      .not_empty (not_empty),
      .rd_data   (rd_data),
      .overflow  (overflow)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_rec(input string req, input int pol, input int cls, input int cnt);
      chk({req, " not_empty"}, int'(not_empty), 1);
      chk({req, " polarity"}, int'(rd_data[W-1]), pol);
      chk({req, " class"}, int'(rd_data[CW+2:CW]), cls);
      if (cnt >= 0) chk({req, " count"}, int'(rd_data[CW-1:0]), cnt);
   endtask

   task automatic pop_one();
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   // drive a level for n cycles; optionally read and pop the record just closed
   task automatic seg(input logic lvl, input int n, input bit rd,
                      input string req, input int pol, input int cls, input int cnt);
      ir_in = lvl;
      if (rd) begin
         repeat (4) @(negedge clk);
         chk_rec(req, pol, cls, cnt);
         pop_one();
         repeat (n - 5) @(negedge clk);
      end else begin
         repeat (n) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 not_empty in reset", int'(not_empty), 0);
      chk("R1 overflow in reset", int'(overflow), 0);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      chk("R1 not_empty after reset", int'(not_empty), 0);
      chk("R1 overflow after reset", int'(overflow), 0);

      // vector table: R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         if (i == 0) begin
            ir_in = 1'b0;
            repeat (4) @(negedge clk);
            chk("R7 first partial interval dropped", int'(not_empty), 0);
            repeat (HOLD[0] - 4) @(negedge clk);
         end else begin
            seg(logic'(i % 2), HOLD[i], 1'b1, $sformatf("R2 R3 R4 R5 R6 vec%0d", i - 1),
                ((i - 1) % 2 == 0) ? 1 : 0, CLS[i - 1],
                (HOLD[i - 1] > CEIL) ? CEIL : HOLD[i - 1]);
         end
      end
      seg(1'b1, 12, 1'b1, "R2 R3 last vec", 1, 7, 20);
      chk("R9 drained after one pop each", int'(not_empty), 0);

      // fill: A(space 12) B(mark 11) C(space 13) D(mark 14), then E dropped
      seg(1'b0, 11, 1'b0, "", 0, 0, 0);
      seg(1'b1, 13, 1'b0, "", 0, 0, 0);
      seg(1'b0, 14, 1'b0, "", 0, 0, 0);
      seg(1'b1, 15, 1'b0, "", 0, 0, 0);
      chk("R10 depth reached without drop", int'(overflow), 0);
      seg(1'b0, 16, 1'b0, "", 0, 0, 0);
      chk("R8 overflow raised", int'(overflow), 1);
      chk_rec("R8 R10 rec A", 0, 7, 12); pop_one();
      chk_rec("R8 R10 rec B", 1, 7, 11); pop_one();
      chk_rec("R8 R10 rec C", 0, 7, 13); pop_one();
      chk_rec("R8 R10 rec D", 1, 7, 14); pop_one();
      chk("R10 only depth records kept", int'(not_empty), 0);
      chk("R8 overflow sticky", int'(overflow), 1);

      // pops on empty queue
      pop_one(); pop_one(); pop_one();
      chk("R9 empty pop keeps empty", int'(not_empty), 0);
      seg(1'b1, 20, 1'b0, "", 0, 0, 0);
      seg(1'b0, 10, 1'b0, "", 0, 0, 0);
      chk_rec("R9 head after empty pops", 1, 7, -1);
      pop_one();
      chk_rec("R9 second after empty pops", 0, 7, 20);
      pop_one();
      chk("R9 empty again", int'(not_empty), 0);
      chk("R8 overflow still sticky", int'(overflow), 1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule